// File: doc/BRIEF.md
# SPI Target Host-Command Port

This block lets an external host talk to a local CPU over a mode-0 SPI link. The host clocks a request into a byte-wide receive FIFO. The CPU drains that FIFO in 32-bit words through a small register interface. A header monitor counts the bytes of each transaction and compares the count with a programmable target. When the count reaches the target, the monitor raises a valid-length interrupt. It also captures a two-byte little-endian length field from a programmable byte position in the request.

While the CPU is still working, every byte the host reads back is a CPU-written status byte. To answer, the CPU takes ownership of the transmit FIFO, fills it in words, marks the fill finished and releases it. The SPI side then shifts the bytes out in order. If the released FIFO runs dry while chip-select is still low, the block sends a fixed filler byte. Raising chip-select ends the transaction, withdraws the release and sets an end-detect interrupt.

The SPI pins are sampled by the system clock through two-stage synchronizers. The SPI clock must therefore be several times slower than `clk`.

Top module: `spi_hostcmd_target`

## Requirements
- R1: After reset, `irq` is low, both FIFO counts, the interrupt status and the captured length read as zero, every interrupt source is masked, and `spi_miso` is low.
- R2: While the transmit FIFO is not released, every byte shifted out on `spi_miso` (MSB first, valid at each rising SPI clock edge) equals the status byte register (address 3, bits 7:0).
- R3: Each received byte is appended to the receive FIFO (count in bits 15:0 of address 13). A CPU read of address 11 while the CPU owns the receive FIFO returns four bytes with the oldest in bits 7:0. It removes at most four bytes.
- R4: The byte index restarts at zero on each chip-select fall. When the byte with index target-1 arrives, interrupt status bit 1 is set. The 16-bit target is held at address 4 (high byte) and address 5 (low byte).
- R5: The byte at index `offset` is captured as length bits 7:0 and the next byte as bits 15:8, readable at address 12. The offset is held at address 6 (high byte) and address 7 (low byte).
- R6: A chip-select rise sets interrupt status bit 0 (address 8). Writing a one to a status bit clears it.
- R7: `irq` is the OR of the status bits whose mask bit (address 9, 1 = masked) is zero. The mask resets to all ones.
- R8: With the CPU owning the transmit FIFO (address 2 = 1), writes to address 10 append four bytes, bits 7:0 first, and the transmit count (bits 31:16 of address 13) grows by four. Command bit 2 (address 1) releases the FIFO only if command bit 1 (fill done) was given first or together with it. Once released, the bytes go out in order.
- R9: When the released transmit FIFO is empty and chip-select is low, the byte sent is 0xEC.
- R10: A chip-select rise withdraws the release and the fill-done mark, so the next transaction sends the status byte again.
- R11: While the CPU owns the receive FIFO (address 2 = 2), incoming bytes are dropped. Writes to address 10 while the CPU does not own the transmit FIFO are ignored.
- R12: With keep-old mode (address 0 bit 1) set, bytes arriving at a full receive FIFO are dropped. With it clear, the oldest byte is discarded to make room.
- R13: With auto-clear (address 0 bit 0) set, a chip-select rise empties the receive FIFO. With it clear, the received data stays.
- R14: Command bit 0 empties the transmit FIFO. Command bit 3 empties the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host, idle low |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Data from the host |
| spi_miso | output | 1 | Data to the host |
| cpu_addr | input | 4 | Register word address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe; data appears on the next cycle |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a FIFO depth of 16 instead of 256. This brings both the full-FIFO drop and the oldest-byte overwrite within reach in a single 18-byte transaction. Header target and length offset are drawn at random over a small range that includes offset zero. This exercises captures near the start of a packet, the exact target hit, and a short packet that stops one byte before the target.

// File: rtl/spit_pkg.sv
package spit_pkg;
  typedef enum logic [3:0] {
    A_CFG   = 4'd0,
    A_CMD   = 4'd1,
    A_OWN   = 4'd2,
    A_STS   = 4'd3,
    A_TGT_H = 4'd4,
    A_TGT_L = 4'd5,
    A_OFS_H = 4'd6,
    A_OFS_L = 4'd7,
    A_ISR   = 4'd8,
    A_IMR   = 4'd9,
    A_TXD   = 4'd10,
    A_RXD   = 4'd11,
    A_LEN   = 4'd12,
    A_CNT   = 4'd13
  } reg_addr_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RX   = 2'd2
  } owner_e;

  localparam int IRQ_N    = 2;
  localparam int IRQ_END  = 0;
  localparam int IRQ_VLEN = 1;

  localparam int CMD_TXRST = 0;
  localparam int CMD_FILL  = 1;
  localparam int CMD_REL   = 2;
  localparam int CMD_RXRST = 3;

  localparam int CFG_AUTOCLR = 0;
  localparam int CFG_KEEPOLD = 1;

  localparam logic [7:0] FILLER = 8'hEC;
endpackage

// File: rtl/spit_fifo.sv
module spit_fifo #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          keep_old,
  input  logic          byte_push,
  input  logic [7:0]    byte_in,
  input  logic          byte_pop,
  output logic [7:0]    byte_out,
  input  logic          word_push,
  input  logic [31:0]   word_in,
  input  logic          word_pop,
  output logic [31:0]   word_out,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d, pop_n, push_n, after;
  logic          wb_en, ww_en, drop_old;

  // next-state: pops are applied before pushes within one cycle
  always_comb begin
    pop_n = '0;
    if (word_pop) pop_n = (cnt_q >= CW'(4)) ? CW'(4) : cnt_q;
    else if (byte_pop && cnt_q != '0) pop_n = CW'(1);
    after    = cnt_q - pop_n;
    push_n   = '0;
    wb_en    = 1'b0;
    ww_en    = 1'b0;
    drop_old = 1'b0;
    if (byte_push) begin
      if (after < CW'(DEPTH)) begin
        push_n = CW'(1);
        wb_en  = 1'b1;
      end else if (!keep_old) begin
        wb_en    = 1'b1;
        drop_old = 1'b1;
      end
    end else if (word_push && after <= CW'(DEPTH - 4)) begin
      push_n = CW'(4);
      ww_en  = 1'b1;
    end
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = wr_q + (ww_en ? AW'(4) : AW'(wb_en));
      rd_d  = rd_q + AW'(pop_n) + AW'(drop_old);
      cnt_d = after + push_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage, no reset
  always_ff @(posedge clk) begin
    if (!clr && wb_en) mem[wr_q] <= byte_in;
    if (!clr && ww_en) begin
      for (int k = 0; k < 4; k++) mem[wr_q + AW'(k)] <= word_in[8*k +: 8];
    end
  end

  always_comb begin
    byte_out = mem[rd_q];
    for (int k = 0; k < 4; k++) word_out[8*k +: 8] = mem[rd_q + AW'(k)];
  end

  assign count = cnt_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R12
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_push && keep_old && !clr && !byte_pop && !word_pop && cnt_q == CW'(DEPTH)
    |=> $stable(wr_q) && $stable(rd_q) && cnt_q == CW'(DEPTH));
endmodule

// File: rtl/spit_shifter.sv
module spit_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       mosi_i,
  input  logic [7:0] load_byte,
  output logic       load_req,
  output logic       miso,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       cs_fall,
  output logic       cs_rise
);
  logic [2:0] sck_q, csn_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_q, bit_d;
  logic [6:0] rxsh_q, rxsh_d;
  logic [7:0] txsh_q, txsh_d;
  logic       sck_rise, sck_fall, active;

  // synchronizer chains, index 2 holds the previous synchronized value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 3'b000;
      csn_q  <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sclk_i};
      csn_q  <= {csn_q[1:0], cs_n_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign cs_fall  = ~csn_q[1] & csn_q[2];
  assign cs_rise  = csn_q[1] & ~csn_q[2];
  assign active   = ~csn_q[1];

  always_comb begin
    bit_d    = bit_q;
    rxsh_d   = rxsh_q;
    txsh_d   = txsh_q;
    load_req = 1'b0;
    rx_valid = 1'b0;
    rx_byte  = {rxsh_q, mosi_q[1]};
    if (cs_fall) begin
      bit_d    = '0;
      txsh_d   = load_byte;
      load_req = 1'b1;
    end else if (active && sck_rise) begin
      rxsh_d = {rxsh_q[5:0], mosi_q[1]};
      bit_d  = bit_q + 3'd1;
      if (bit_q == 3'd7) rx_valid = 1'b1;
    end else if (active && sck_fall) begin
      if (bit_q == 3'd0) begin
        txsh_d   = load_byte;
        load_req = 1'b1;
      end else begin
        txsh_d = {txsh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rxsh_q <= '0;
      txsh_q <= '0;
    end else begin
      bit_q  <= bit_d;
      rxsh_q <= rxsh_d;
      txsh_q <= txsh_d;
    end
  end

  assign miso = txsh_q[7];
endmodule

// File: rtl/spit_hdrmon.sv
module spit_hdrmon (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [15:0] target,
  input  logic [15:0] offset,
  output logic        hit,
  output logic [15:0] len
);
  logic [15:0] idx_q, idx_d, len_d;
  logic [16:0] idx_nx;

  assign idx_nx = {1'b0, idx_q} + 17'd1;
  assign hit    = rx_valid && (idx_nx == {1'b0, target});

  always_comb begin
    idx_d = idx_q;
    len_d = len;
    if (start) begin
      idx_d = '0;
    end else if (rx_valid) begin
      if (idx_q == offset) len_d[7:0] = rx_byte;
      if ({1'b0, idx_q} == {1'b0, offset} + 17'd1) len_d[15:8] = rx_byte;
      if (idx_q != 16'hFFFF) idx_d = idx_nx[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      len   <= '0;
    end else begin
      idx_q <= idx_d;
      len   <= len_d;
    end
  end
endmodule

// File: rtl/spi_hostcmd_target.sv
module spi_hostcmd_target
  import spit_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic [3:0]  cpu_addr,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        irq
);
  logic [1:0]       cfg_q, cfg_d;
  logic [1:0]       own_q, own_d;
  logic [7:0]       sts_q, sts_d;
  logic [15:0]      tgt_q, tgt_d, ofs_q, ofs_d;
  logic [IRQ_N-1:0] isr_q, isr_d, imr_q, imr_d;
  logic             fill_q, fill_d, live_q, live_d;
  logic [31:0]      rdata_d;

  logic       load_req, rx_valid, cs_fall, cs_rise, hit;
  logic [7:0] rx_byte, load_byte, tx_head, rx_head_b;
  logic [31:0] rx_word, tx_word_unused;
  logic [15:0] len;
  logic [CW-1:0] rx_cnt, tx_cnt;

  logic wr_cmd, tx_rst, rx_clr, tx_push, tx_pop, rx_push, rx_pop;
  reg_addr_e a;

  assign a       = reg_addr_e'(cpu_addr);
  assign wr_cmd  = cpu_wr && a == A_CMD;
  assign tx_rst  = wr_cmd && cpu_wdata[CMD_TXRST];
  assign rx_clr  = (wr_cmd && cpu_wdata[CMD_RXRST]) || (cs_rise && cfg_q[CFG_AUTOCLR]);
  assign tx_push = cpu_wr && a == A_TXD && own_q == OWN_TX;
  assign rx_pop  = cpu_rd && a == A_RXD && own_q == OWN_RX;
  assign rx_push = rx_valid && own_q != OWN_RX;
  assign tx_pop  = load_req && live_q && tx_cnt != '0;

  // byte presented to the shifter at each byte boundary
  always_comb begin
    if (!live_q)             load_byte = sts_q;
    else if (tx_cnt == '0)   load_byte = FILLER;
    else                     load_byte = tx_head;
  end

  spit_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (spi_sclk),
    .cs_n_i    (spi_cs_n),
    .mosi_i    (spi_mosi),
    .load_byte (load_byte),
    .load_req  (load_req),
    .miso      (spi_miso),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise)
  );

  spit_hdrmon u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cs_fall),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .target   (tgt_q),
    .offset   (ofs_q),
    .hit      (hit),
    .len      (len)
  );

  spit_fifo #(.DEPTH(FIFO_DEPTH)) u_rxf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .keep_old  (cfg_q[CFG_KEEPOLD]),
    .byte_push (rx_push),
    .byte_in   (rx_byte),
    .byte_pop  (1'b0),
    .byte_out  (rx_head_b),
    .word_push (1'b0),
    .word_in   (32'd0),
    .word_pop  (rx_pop),
    .word_out  (rx_word),
    .count     (rx_cnt)
  );

  spit_fifo #(.DEPTH(FIFO_DEPTH)) u_txf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tx_rst),
    .keep_old  (1'b1),
    .byte_push (1'b0),
    .byte_in   (8'd0),
    .byte_pop  (tx_pop),
    .byte_out  (tx_head),
    .word_push (tx_push),
    .word_in   (cpu_wdata),
    .word_pop  (1'b0),
    .word_out  (tx_word_unused),
    .count     (tx_cnt)
  );

  // register next-state
  always_comb begin
    cfg_d  = cfg_q;
    own_d  = own_q;
    sts_d  = sts_q;
    tgt_d  = tgt_q;
    ofs_d  = ofs_q;
    imr_d  = imr_q;
    isr_d  = isr_q;
    fill_d = fill_q;
    live_d = live_q;
    if (cpu_wr) begin
      unique case (a)
        A_CFG:   cfg_d = cpu_wdata[1:0];
        A_OWN:   own_d = cpu_wdata[1:0];
        A_STS:   sts_d = cpu_wdata[7:0];
        A_TGT_H: tgt_d[15:8] = cpu_wdata[7:0];
        A_TGT_L: tgt_d[7:0]  = cpu_wdata[7:0];
        A_OFS_H: ofs_d[15:8] = cpu_wdata[7:0];
        A_OFS_L: ofs_d[7:0]  = cpu_wdata[7:0];
        A_IMR:   imr_d = cpu_wdata[IRQ_N-1:0];
        A_ISR:   isr_d = isr_q & ~cpu_wdata[IRQ_N-1:0];
        default: ;
      endcase
    end
    if (wr_cmd && cpu_wdata[CMD_FILL]) fill_d = 1'b1;
    if (wr_cmd && cpu_wdata[CMD_REL] && (fill_q || cpu_wdata[CMD_FILL])) live_d = 1'b1;
    if (tx_rst || cs_rise) begin
      fill_d = 1'b0;
      live_d = 1'b0;
    end
    if (cs_rise) isr_d[IRQ_END]  = 1'b1;
    if (hit)     isr_d[IRQ_VLEN] = 1'b1;
  end

  always_comb begin
    rdata_d = '0;
    unique case (a)
      A_CFG:   rdata_d[1:0] = cfg_q;
      A_OWN:   rdata_d[1:0] = own_q;
      A_STS:   rdata_d[7:0] = sts_q;
      A_TGT_H: rdata_d[7:0] = tgt_q[15:8];
      A_TGT_L: rdata_d[7:0] = tgt_q[7:0];
      A_OFS_H: rdata_d[7:0] = ofs_q[15:8];
      A_OFS_L: rdata_d[7:0] = ofs_q[7:0];
      A_ISR:   rdata_d[IRQ_N-1:0] = isr_q;
      A_IMR:   rdata_d[IRQ_N-1:0] = imr_q;
      A_RXD:   rdata_d = (own_q == OWN_RX) ? rx_word : 32'd0;
      A_LEN:   rdata_d[15:0] = len;
      A_CNT:   rdata_d = {16'(tx_cnt), 16'(rx_cnt)};
      default: rdata_d = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      own_q     <= OWN_NONE;
      sts_q     <= '0;
      tgt_q     <= '0;
      ofs_q     <= '0;
      isr_q     <= '0;
      imr_q     <= '1;
      fill_q    <= 1'b0;
      live_q    <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cfg_q  <= cfg_d;
      own_q  <= own_d;
      sts_q  <= sts_d;
      tgt_q  <= tgt_d;
      ofs_q  <= ofs_d;
      isr_q  <= isr_d;
      imr_q  <= imr_d;
      fill_q <= fill_d;
      live_q <= live_d;
      if (cpu_rd) cpu_rdata <= rdata_d;
    end
  end

  assign irq = |(isr_q & ~imr_q);

  // R6
  end_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> isr_q[IRQ_END]);

  // R4
  vlen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> isr_q[IRQ_VLEN]);

  // R10
  release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !live_q && !fill_q);

  // R14
  tx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> tx_cnt == '0);

  // R11
  rx_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && own_q == OWN_RX && !rx_clr && !rx_pop |=> $stable(rx_cnt));

  // R9
  filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && live_q && tx_cnt == '0 && !cs_rise |=> $stable(tx_cnt));
endmodule

// File: tb/test_spi_hostcmd_target.sv
module test_spi_hostcmd_target;
  localparam int DEPTH = 16;

  logic        clk, rst_n;
  logic        sclk, cs_n, mosi, miso;
  logic [3:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata, rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  spi_hostcmd_target #(.FIFO_DEPTH(DEPTH)) i_spi_hostcmd_target (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .cpu_addr(addr), .cpu_wr(wr), .cpu_rd(rd), .cpu_wdata(wdata),
    .cpu_rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_w(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic cpu_r(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs_n = 1'b0;
    tick(8);
  endtask

  task automatic cs_off();
    tick(8);
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      tick(8);
      sclk = 1'b1;
      r[i] = miso;
      tick(8);
      sclk = 1'b0;
    end
  endtask

  function automatic logic [31:0] pack4(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  d [24];
    logic [7:0]  r [24];
    logic [31:0] v, w0, w1;
    int off, tgt;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    tick(4);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 miso", {31'd0, miso}, 32'd0);
    cpu_r(4'd13, v); check("R1 counts", v, 32'd0);
    cpu_r(4'd8, v);  check("R1 status", v, 32'd0);
    cpu_r(4'd9, v);  check("R1 mask", v, 32'd3);
    cpu_r(4'd12, v); check("R1 length", v, 32'd0);

    // R2 status byte, R3 receive path
    cpu_w(4'd3, 32'hA5);
    cpu_w(4'd1, 32'h8);
    for (int i = 0; i < 6; i++) d[i] = 8'($urandom);
    cs_on();
    for (int i = 0; i < 6; i++) xfer(d[i], r[i]);
    cs_off();
    for (int i = 0; i < 6; i++) check("R2 status byte out", {24'd0, r[i]}, 32'hA5);
    cpu_r(4'd13, v); check("R3 rx count", v & 32'hFFFF, 32'd6);
    cpu_w(4'd2, 32'd2);
    cpu_r(4'd11, v); check("R3 rx word0", v, pack4(d[0], d[1], d[2], d[3]));
    cpu_r(4'd11, v); check("R3 rx word1", v & 32'hFFFF, {16'd0, d[5], d[4]});
    cpu_r(4'd13, v); check("R3 rx drained", v & 32'hFFFF, 32'd0);
    cpu_w(4'd2, 32'd0);
    cpu_r(4'd8, v); check("R6 end detect set", v & 32'd1, 32'd1);
    cpu_w(4'd8, 32'd1);
    cpu_r(4'd8, v); check("R6 write one clears", v & 32'd1, 32'd0);

    // R4 R5 R7 directed header
    cpu_w(4'd4, 32'd0); cpu_w(4'd5, 32'd5);
    cpu_w(4'd6, 32'd0); cpu_w(4'd7, 32'd2);
    cpu_w(4'd9, 32'd0); cpu_w(4'd8, 32'd3);
    cs_on();
    xfer(8'h03, r[0]); xfer(8'h77, r[1]); xfer(8'h34, r[2]); xfer(8'h12, r[3]);
    tick(4);
    cpu_r(4'd8, v); check("R4 before target", v, 32'd0);
    check("R7 irq low", {31'd0, irq}, 32'd0);
    xfer(8'h55, r[4]);
    tick(4);
    cpu_r(4'd8, v); check("R4 target reached", v, 32'd2);
    check("R7 irq high", {31'd0, irq}, 32'd1);
    cpu_r(4'd12, v); check("R5 length field", v, 32'h1234);
    cs_off();
    cpu_r(4'd8, v); check("R6 both set", v, 32'd3);
    cpu_w(4'd9, 32'd3);
    check("R7 all masked", {31'd0, irq}, 32'd0);
    cpu_w(4'd9, 32'd1);
    check("R7 vlen unmasked", {31'd0, irq}, 32'd1);
    cpu_w(4'd8, 32'd3);
    check("R7 cleared", {31'd0, irq}, 32'd0);

    // R4 R5 randomized offset and target
    for (int it = 0; it < 4; it++) begin
      off = int'($urandom % 6);
      tgt = off + 2 + int'($urandom % 4);
      cpu_w(4'd5, 32'(tgt)); cpu_w(4'd7, 32'(off));
      cpu_w(4'd8, 32'd3);
      for (int i = 0; i < tgt; i++) d[i] = 8'($urandom);
      cs_on();
      for (int i = 0; i < tgt - 1; i++) xfer(d[i], r[i]);
      cs_off();
      cpu_r(4'd8, v); check("R4 short packet", v & 32'd2, 32'd0);
      cpu_w(4'd8, 32'd3);
      cs_on();
      for (int i = 0; i < tgt; i++) xfer(d[i], r[i]);
      cs_off();
      cpu_r(4'd8, v); check("R4 random target", v & 32'd2, 32'd2);
      cpu_r(4'd12, v); check("R5 random offset", v, {16'd0, d[off + 1], d[off]});
    end
    cpu_w(4'd9, 32'd3);

    // R8 R9 transmit path
    w0 = $urandom; w1 = $urandom;
    cpu_w(4'd1, 32'h1);
    cpu_w(4'd2, 32'd1);
    cpu_w(4'd10, w0); cpu_w(4'd10, w1);
    cpu_r(4'd13, v); check("R8 tx count", v >> 16, 32'd8);
    cpu_w(4'd1, 32'h2);
    cpu_w(4'd1, 32'h4);
    cpu_w(4'd2, 32'd0);
    cs_on();
    for (int i = 0; i < 10; i++) xfer(8'($urandom), r[i]);
    cs_off();
    for (int i = 0; i < 4; i++) check("R8 tx byte w0", {24'd0, r[i]}, {24'd0, w0[8*i +: 8]});
    for (int i = 0; i < 4; i++) check("R8 tx byte w1", {24'd0, r[4+i]}, {24'd0, w1[8*i +: 8]});
    check("R9 filler 1", {24'd0, r[8]}, 32'hEC);
    check("R9 filler 2", {24'd0, r[9]}, 32'hEC);

    // R10 release withdrawn at end
    cs_on();
    xfer(8'h00, r[0]); xfer(8'h00, r[1]);
    cs_off();
    check("R10 status again 0", {24'd0, r[0]}, 32'hA5);
    check("R10 status again 1", {24'd0, r[1]}, 32'hA5);

    // R8 release without fill-done
    cpu_w(4'd1, 32'h1);
    cpu_w(4'd2, 32'd1);
    cpu_w(4'd10, 32'h11223344);
    cpu_w(4'd2, 32'd0);
    cpu_w(4'd1, 32'h4);
    cs_on();
    xfer(8'h00, r[0]); xfer(8'h00, r[1]);
    cs_off();
    check("R8 no fill no release", {24'd0, r[0]}, 32'hA5);
    cpu_r(4'd13, v); check("R8 tx untouched", v >> 16, 32'd4);

    // R14 transmit reset
    cpu_w(4'd1, 32'h1);
    cpu_r(4'd13, v); check("R14 tx emptied", v >> 16, 32'd0);

    // R11 ownership
    cpu_w(4'd10, 32'hDEADBEEF);
    cpu_r(4'd13, v); check("R11 tx write unowned", v >> 16, 32'd0);
    cpu_w(4'd1, 32'h8);
    cpu_w(4'd2, 32'd2);
    cs_on();
    for (int i = 0; i < 3; i++) xfer(8'($urandom), r[i]);
    cs_off();
    cpu_r(4'd13, v); check("R11 rx dropped while owned", v & 32'hFFFF, 32'd0);
    cpu_w(4'd2, 32'd0);

    // R12 keep-old and overwrite
    for (int i = 0; i < DEPTH + 2; i++) d[i] = 8'($urandom);
    cpu_w(4'd0, 32'd2);
    cpu_w(4'd1, 32'h8);
    cs_on();
    for (int i = 0; i < DEPTH + 2; i++) xfer(d[i], r[i]);
    cs_off();
    cpu_r(4'd13, v); check("R12 full count", v & 32'hFFFF, 32'(DEPTH));
    cpu_w(4'd2, 32'd2);
    for (int k = 0; k < DEPTH / 4; k++) begin
      cpu_r(4'd11, v);
      check("R12 keep old data", v, pack4(d[4*k], d[4*k+1], d[4*k+2], d[4*k+3]));
    end
    cpu_w(4'd2, 32'd0);
    cpu_w(4'd0, 32'd0);
    cpu_w(4'd1, 32'h8);
    cs_on();
    for (int i = 0; i < DEPTH + 2; i++) xfer(d[i], r[i]);
    cs_off();
    cpu_w(4'd2, 32'd2);
    for (int k = 0; k < DEPTH / 4; k++) begin
      cpu_r(4'd11, v);
      check("R12 overwrite oldest", v, pack4(d[4*k+2], d[4*k+3], d[4*k+4], d[4*k+5]));
    end
    cpu_w(4'd2, 32'd0);

    // R13 auto-clear
    cpu_w(4'd0, 32'd1);
    cpu_w(4'd1, 32'h8);
    cs_on();
    for (int i = 0; i < 3; i++) xfer(8'($urandom), r[i]);
    cs_off();
    cpu_r(4'd13, v); check("R13 auto cleared", v & 32'hFFFF, 32'd0);
    cpu_w(4'd0, 32'd0);
    cs_on();
    for (int i = 0; i < 3; i++) xfer(8'($urandom), r[i]);
    cs_off();
    cpu_r(4'd13, v); check("R13 retained", v & 32'hFFFF, 32'd3);
    cpu_w(4'd1, 32'h8);
    cpu_r(4'd13, v); check("R14 rx emptied", v & 32'hFFFF, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule